// File: doc/BRIEF.md
# Processor Cycle Stretcher with Deferred Halt

This block turns a fast master clock into a one-tick step enable for a processor, one pulse per processor cycle. A cycle normally lasts four master ticks. When the program-counter address presented at the end of a cycle falls into a slow peripheral window, the following cycle is stretched to six ticks. One window, the low page, counts as slow only while an external lock bit is set. The length of a cycle is fixed when it starts and never changes part way through.

A video DMA engine can pause the processor through single-tick halt and resume requests. Each request is held until the next cycle boundary, where it takes effect. A haltable flag tells the DMA engine whether the current cycle is still early enough to be halted. A cycle counter advances once per processor cycle even while the processor is halted. Alongside the cycle logic, a free-running horizontal counter raises audio sample strobes at two fixed positions, and a divider produces a timer tick for a peripheral.

Top module: `cpu_clk_stretch`

## Requirements
- R1: A processor cycle lasts 4 master ticks when fast and 6 when slow. `cpu_step` pulses for one tick, on the last tick of each cycle, only while `halted` is low.
- R2: An address with bits [15:10] and bits [7:5] all zero (the low page) makes the next cycle slow when `lock_bit` is 1, and fast when `lock_bit` is 0.
- R3: An address with bits [15:7] equal to 9'b000000101 (0x0280..0x02FF), or with bits [15:9] equal to 7'b0000010 and bit 7 set, makes the next cycle slow regardless of `lock_bit`. Every other address outside the low page makes it fast.
- R4: `pc_addr` and `lock_bit` are sampled only on the last tick of a cycle. `slow_cycle` shows the speed of the current cycle and changes only at a cycle boundary.
- R5: `haltable` is high during the first 2 ticks of a fast cycle or the first 3 ticks of a slow cycle, and low for the rest of the cycle.
- R6: A pulse on `halt_req` or `resume_req` is held pending and applied at the next cycle boundary. If both are pending at that boundary, resume wins and `halted` ends low. A request arriving on a boundary tick is applied at the following boundary.
- R7: `cycle_count` increments by one at every cycle boundary, whether or not the processor is halted.
- R8: `hcount` increments every master tick and wraps from 453 to 0. `audio_strobe` is high exactly while `hcount` is 113 or 340.
- R9: `timer_tick` is high on every fourth master tick, first on the fourth tick after reset.
- R10: A synchronous active-high `rst` clears all counters and the halted and pending state, and selects a fast cycle. During reset `haltable` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_addr | input | 16 | Program-counter address to decode for the next cycle |
| lock_bit | input | 1 | Makes the low page slow when set |
| halt_req | input | 1 | One-tick halt request from the DMA engine |
| resume_req | input | 1 | One-tick resume request from the DMA engine |
| cpu_step | output | 1 | Processor step enable |
| haltable | output | 1 | The current cycle may still be halted |
| halted | output | 1 | The processor is halted |
| slow_cycle | output | 1 | The current cycle is a six-tick cycle |
| cycle_count | output | 32 | Number of processor cycles since reset |
| hcount | output | 9 | Horizontal position counter |
| audio_strobe | output | 1 | Audio sample strobe |
| timer_tick | output | 1 | Peripheral timer tick |

## Verification
Some properties are checked on every cycle. The in-cycle position stays within the current cycle length. `halted` and `slow_cycle` change only on a boundary tick. The cycle counter steps by one at each boundary. `haltable` is never high on a boundary tick. The horizontal counter stays in range and wraps to zero, and the timer tick never lasts two ticks.

Other behaviour can only be shown by the bench, which runs a tick-accurate model against the outputs. This covers the address decode across the three windows with the lock bit in both states, and the resume-over-halt priority. It also covers a request that lands exactly on a boundary tick, and the strobe positions across a full line wrap.

// File: rtl/cstr_pkg.sv
package cstr_pkg;

    typedef enum logic {
        ACC_FAST = 1'b0,
        ACC_SLOW = 1'b1
    } acc_speed_t;

    typedef struct packed {
        logic audio;
        logic timer;
    } line_evt_t;

    // Decide the speed of the next access from the address and the lock bit.
    function automatic acc_speed_t cstr_decode(input logic [15:0] a, input logic lock);
        logic low_page;
        logic io_win;
        logic ram_win;
        low_page = ((a & 16'hFCE0) == 16'h0000);
        io_win   = ((a & 16'hFF80) == 16'h0280);
        ram_win  = ((a & 16'hFE80) == 16'h0480);
        return ((low_page && lock) || io_win || ram_win) ? ACC_SLOW : ACC_FAST;
    endfunction

endpackage

// File: rtl/cstr_cycle_seq.sv
module cstr_cycle_seq
    import cstr_pkg::*;
#(
    parameter int FAST_TICKS    = 4,
    parameter int SLOW_TICKS    = 6,
    parameter int HALT_WIN_FAST = 2,
    parameter int HALT_WIN_SLOW = 3,
    parameter int CNT_W         = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      pc_addr,
    input  logic             lock_bit,
    input  logic             halt_req,
    input  logic             resume_req,
    output logic             cpu_step,
    output logic             haltable,
    output logic             halted,
    output logic             slow_cycle,
    output logic [CNT_W-1:0] cycle_count
);
    localparam int TICK_W = $clog2(SLOW_TICKS);
    localparam logic [TICK_W-1:0] LAST_FAST = TICK_W'(FAST_TICKS - 1);
    localparam logic [TICK_W-1:0] LAST_SLOW = TICK_W'(SLOW_TICKS - 1);
    localparam logic [TICK_W-1:0] WIN_FAST  = TICK_W'(HALT_WIN_FAST);
    localparam logic [TICK_W-1:0] WIN_SLOW  = TICK_W'(HALT_WIN_SLOW);

    logic [TICK_W-1:0] pos_q;
    acc_speed_t        speed_q;
    logic              halted_q;
    logic              halt_pend_q;
    logic              resume_pend_q;
    logic [CNT_W-1:0]  count_q;
    logic              cycle_last;
    logic              halted_next;

    always_comb begin
        cycle_last = (pos_q == ((speed_q == ACC_SLOW) ? LAST_SLOW : LAST_FAST));
        haltable   = (pos_q < ((speed_q == ACC_SLOW) ? WIN_SLOW : WIN_FAST));
        cpu_step   = cycle_last && !halted_q;
        // Halt applies first, resume after it, so resume wins.
        halted_next = halted_q;
        if (halt_pend_q)   halted_next = 1'b1;
        if (resume_pend_q) halted_next = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q         <= '0;
            speed_q       <= ACC_FAST;
            halted_q      <= 1'b0;
            halt_pend_q   <= 1'b0;
            resume_pend_q <= 1'b0;
            count_q       <= '0;
        end else if (cycle_last) begin
            pos_q         <= '0;
            speed_q       <= cstr_decode(pc_addr, lock_bit);
            halted_q      <= halted_next;
            halt_pend_q   <= halt_req;
            resume_pend_q <= resume_req;
            count_q       <= count_q + 1'b1;
        end else begin
            pos_q         <= pos_q + 1'b1;
            halt_pend_q   <= halt_pend_q | halt_req;
            resume_pend_q <= resume_pend_q | resume_req;
        end
    end

    assign halted      = halted_q;
    assign slow_cycle  = (speed_q == ACC_SLOW);
    assign cycle_count = count_q;

    // R1: position never passes the last tick of the current cycle length
    assert_pos_bound_R1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= ((speed_q == ACC_SLOW) ? LAST_SLOW : LAST_FAST));

    // R4: speed is held for the whole cycle
    assert_speed_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cycle_last |=> $stable(speed_q));

    // R5: the haltable window closes before the boundary tick
    assert_haltable_early_R5: assert property (@(posedge clk) disable iff (rst)
        haltable |-> !cycle_last);

    // R6: halted state moves only at a boundary
    assert_halt_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        !cycle_last |=> $stable(halted_q));

    // R7: one count per processor cycle, halted or not
    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        cycle_last |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/cstr_line_timer.sv
module cstr_line_timer
    import cstr_pkg::*;
#(
    parameter int HC_WRAP   = 454,
    parameter int AUD_POS_A = 113,
    parameter int AUD_POS_B = 340,
    parameter int TIMER_DIV = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(HC_WRAP)-1:0] hcount,
    output line_evt_t                  evt
);
    localparam int HC_W  = $clog2(HC_WRAP);
    localparam int DIV_W = $clog2(TIMER_DIV);
    localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HC_WRAP - 1);
    localparam logic [HC_W-1:0]  AUD_A    = HC_W'(AUD_POS_A);
    localparam logic [HC_W-1:0]  AUD_B    = HC_W'(AUD_POS_B);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TIMER_DIV - 1);

    logic [HC_W-1:0]  hc_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_q  <= '0;
            div_q <= '0;
        end else begin
            hc_q  <= (hc_q == HC_LAST) ? '0 : hc_q + 1'b1;
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    always_comb begin
        evt.audio = (hc_q == AUD_A) || (hc_q == AUD_B);
        evt.timer = (div_q == DIV_LAST);
    end

    assign hcount = hc_q;

    // R8: counter stays inside the line and wraps to zero
    assert_hc_range_R8: assert property (@(posedge clk) disable iff (rst)
        hc_q <= HC_LAST);
    assert_hc_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (hc_q == HC_LAST) |=> (hc_q == '0));

    // R9: the timer tick is a single-tick pulse
    assert_timer_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        evt.timer |=> !evt.timer);

endmodule

// File: rtl/cpu_clk_stretch.sv
module cpu_clk_stretch
    import cstr_pkg::*;
#(
    parameter int FAST_TICKS    = 4,
    parameter int SLOW_TICKS    = 6,
    parameter int HALT_WIN_FAST = 2,
    parameter int HALT_WIN_SLOW = 3,
    parameter int CNT_W         = 32,
    parameter int HC_WRAP       = 454,
    parameter int AUD_POS_A     = 113,
    parameter int AUD_POS_B     = 340,
    parameter int TIMER_DIV     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                pc_addr,
    input  logic                       lock_bit,
    input  logic                       halt_req,
    input  logic                       resume_req,
    output logic                       cpu_step,
    output logic                       haltable,
    output logic                       halted,
    output logic                       slow_cycle,
    output logic [CNT_W-1:0]           cycle_count,
    output logic [$clog2(HC_WRAP)-1:0] hcount,
    output logic                       audio_strobe,
    output logic                       timer_tick
);
    line_evt_t line_evt;

    cstr_cycle_seq #(
        .FAST_TICKS    (FAST_TICKS),
        .SLOW_TICKS    (SLOW_TICKS),
        .HALT_WIN_FAST (HALT_WIN_FAST),
        .HALT_WIN_SLOW (HALT_WIN_SLOW),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .pc_addr     (pc_addr),
        .lock_bit    (lock_bit),
        .halt_req    (halt_req),
        .resume_req  (resume_req),
        .cpu_step    (cpu_step),
        .haltable    (haltable),
        .halted      (halted),
        .slow_cycle  (slow_cycle),
        .cycle_count (cycle_count)
    );

    cstr_line_timer #(
        .HC_WRAP   (HC_WRAP),
        .AUD_POS_A (AUD_POS_A),
        .AUD_POS_B (AUD_POS_B),
        .TIMER_DIV (TIMER_DIV)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .hcount (hcount),
        .evt    (line_evt)
    );

    assign audio_strobe = line_evt.audio;
    assign timer_tick   = line_evt.timer;

    // R1: a step can only be issued while not halted
    assert_step_unhalted_R1: assert property (@(posedge clk) disable iff (rst)
        cpu_step |-> !halted);

endmodule

// File: tb/cpu_clk_stretch_bench.sv
module cpu_clk_stretch_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc_addr = '0;
    logic        lock_bit = 1'b0;
    logic        halt_req = 1'b0;
    logic        resume_req = 1'b0;
    logic        cpu_step, haltable, halted, slow_cycle, audio_strobe, timer_tick;
    logic [31:0] cycle_count;
    logic [8:0]  hcount;

    always #2 clk = ~clk;

    cpu_clk_stretch u_cpu_clk_stretch (
        .clk(clk), .rst(rst), .pc_addr(pc_addr), .lock_bit(lock_bit),
        .halt_req(halt_req), .resume_req(resume_req), .cpu_step(cpu_step),
        .haltable(haltable), .halted(halted), .slow_cycle(slow_cycle),
        .cycle_count(cycle_count), .hcount(hcount),
        .audio_strobe(audio_strobe), .timer_tick(timer_tick)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    int    m_pos, m_cnt, m_hc, m_div;
    bit    m_slow, m_halted, m_hp, m_rp;

    function automatic bit ref_slow(input logic [15:0] a, input logic lock);
        bit low  = (a[15:10] == 6'd0) && (a[7:5] == 3'd0);
        bit io   = (a[15:7] == 9'b000000101);
        bit ram  = (a[15:9] == 7'b0000010) && a[7];
        return (low && lock) || io || ram;
    endfunction

    function automatic bit m_last();
        return m_pos == (m_slow ? 5 : 3);
    endfunction

    task automatic chk(input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic model_step(input logic [15:0] a, input logic lk, input logic h, input logic r);
        if (m_last()) begin
            m_pos = 0;
            m_cnt++;
            if (m_hp) m_halted = 1'b1;
            if (m_rp) m_halted = 1'b0;
            m_slow = ref_slow(a, lk);
            m_hp = h;
            m_rp = r;
        end else begin
            m_pos++;
            m_hp = m_hp | h;
            m_rp = m_rp | r;
        end
        m_hc  = (m_hc + 1) % 454;
        m_div = (m_div + 1) % 4;
    endtask

    task automatic compare_all();
        chk("R1 cpu_step", cpu_step, m_last() && !m_halted);
        chk("R5 haltable", haltable, m_pos < (m_slow ? 3 : 2));
        chk("R6 halted", halted, m_halted);
        chk("R2/R3/R4 slow_cycle", slow_cycle, m_slow);
        chk("R7 cycle_count", cycle_count, m_cnt);
        chk("R8 hcount", hcount, m_hc);
        chk("R8 audio_strobe", audio_strobe, (m_hc == 113) || (m_hc == 340));
        chk("R9 timer_tick", timer_tick, m_div == 3);
    endtask

    task automatic tick(input logic [15:0] a, input logic lk, input logic h, input logic r);
        @(negedge clk);
        compare_all();
        pc_addr = a; lock_bit = lk; halt_req = h; resume_req = r;
        model_step(a, lk, h, r);
    endtask

    function automatic logic [15:0] pick_addr(input int sel);
        logic [15:0] v = 16'($urandom);
        case (sel)
            0: return {6'd0, v[9:8], 3'd0, v[4:0]};
            1: return {9'b000000101, v[6:0]};
            2: return {7'b0000010, v[8], 1'b1, v[6:0]};
            default: return v;
        endcase
    endfunction

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_pos = 0; m_cnt = 0; m_hc = 0; m_div = 0;
        m_slow = 0; m_halted = 0; m_hp = 0; m_rp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        chk("R10 reset cpu_step", cpu_step, 0);
        chk("R10 reset haltable", haltable, 1);
        chk("R10 reset halted", halted, 0);
        chk("R10 reset slow_cycle", slow_cycle, 0);
        chk("R10 reset cycle_count", cycle_count, 0);
        chk("R10 reset hcount", hcount, 0);
        chk("R10 reset audio_strobe", audio_strobe, 0);
        chk("R10 reset timer_tick", timer_tick, 0);
        rst = 1'b0;
        model_step(16'h0, 1'b0, 1'b0, 1'b0);

        // R2/R3 directed windows, each held for a full pair of cycles
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a;
            logic        lk;
            case (k)
                0: begin a = 16'h0000; lk = 0; end
                1: begin a = 16'h0000; lk = 1; end
                2: begin a = 16'h031F; lk = 1; end
                3: begin a = 16'h0020; lk = 1; end
                4: begin a = 16'h0280; lk = 0; end
                5: begin a = 16'h02FF; lk = 0; end
                6: begin a = 16'h0300; lk = 1; end
                7: begin a = 16'h0480; lk = 0; end
                8: begin a = 16'h05FF; lk = 0; end
                9: begin a = 16'h0400; lk = 1; end
                10: begin a = 16'h0C80; lk = 1; end
                default: begin a = 16'h1000; lk = 1; end
            endcase
            repeat (12) tick(a, lk, 0, 0);
        end

        // R6: halt, then resume, then both together, with fast and slow cycles
        tick(16'h1000, 0, 1, 0);
        repeat (10) tick(16'h0290, 0, 0, 0);
        tick(16'h1000, 0, 0, 1);
        repeat (10) tick(16'h1000, 0, 0, 0);
        tick(16'h1000, 0, 1, 0);
        repeat (8) tick(16'h1000, 0, 0, 0);
        tick(16'h1000, 0, 1, 1);
        repeat (8) tick(16'h1000, 0, 0, 0);

        // random phase: requests including boundary-tick arrivals
        for (int n = 0; n < 4000; n++) begin
            int sel = int'($urandom_range(0, 3));
            logic h = ($urandom_range(0, 15) == 0);
            logic r = ($urandom_range(0, 15) == 0);
            tick(pick_addr(sel), logic'($urandom_range(0, 1)), h, r);
        end
        tick(16'h0, 0, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule